// File: doc/BRIEF.md
# Two-Phase Clock Stop and Wake Controller

This block derives a pair of complementary processor clock phases, H1 and H3, from a free-running input clock. Each phase toggles on every input clock edge, so one H1 cycle spans two input clock cycles. The block watches a decoded-instruction port for a halt opcode. When that opcode arrives it freezes both phases in a fixed state and quiets the external bus. The address is held, the data drivers are released and every control strobe is forced inactive.

The clocks restart when one of four active-low interrupt lines stays asserted long enough. The interrupt lines are synchronized and their width is counted on the free-running input clock, so the filter keeps working while H1 and H3 are stopped. A one-cycle wake pulse and a halted flag tell the core to begin interrupt service before it fetches the instruction after the halt. An emulation-mode input turns the halt into an ordinary idle: the clocks keep running and only an idle flag is raised. A separate pulse flags an interrupt held long enough to count as a repeated level-triggered request.

Top module: `clkstop_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets to h1_o=1, h3_o=0, halted_o=0, idle_o=0, wake_o=0 and rep_o=0.
- R2: When not halted, h1_o and h3_o each invert on every clk_i edge, and h3_o is always the inverse of h1_o.
- R3: A halt request is instr_valid_i=1 with instr_word_i equal to 32'h0600_0001 and emu_mode_i=0. Within two clk_i cycles of the request edge, halted_o is 1. From the second halted cycle on, h1_o stays 1 and h3_o stays 0 until the wake sequence.
- R4: Any other instruction word, and the halt word presented with instr_valid_i=0, leaves halted_o and idle_o at 0, and the clocks keep toggling.
- R5: While halted_o is 1: data_oe_o is 0; strb_n_o is all ones; addr_o keeps the address that was present in the cycle of the halt request, whatever addr_core_i does.
- R6: A halt request made with emu_mode_i=1 sets idle_o and leaves halted_o at 0, with the clocks still toggling. A qualifying interrupt then clears idle_o and produces one wake_o pulse.
- R7: An interrupt line qualifies for wake-up only after four consecutive clk_i cycles (two H1 cycles) low, counted after a two-flop synchronizer. A pulse three clk_i cycles long does not end a halt.
- R8: After a qualifying interrupt, halted_o stays 1 for one more H1 cycle (two clk_i cycles) and then falls. In the first cycle with halted_o low, h1_o is 0 (the phase opposite to the frozen one) and wake_o is 1, for exactly one cycle.
- R9: rep_o pulses once, for one cycle, when a line has been low for six consecutive synchronized clk_i cycles (three H1 cycles). A two-H1-cycle pulse gives exactly one wake pulse and no rep_o pulse.
- R10: Each of the four interrupt lines int_n_i[0] to int_n_i[3] can end a halt on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid_i | input | 1 | Decoded instruction word is valid this cycle |
| instr_word_i | input | 32 | Decoded instruction word |
| emu_mode_i | input | 1 | Emulation mode: halt becomes idle, clocks keep running |
| int_n_i | input | 4 | Active-low external interrupt lines |
| addr_core_i | input | AW | Address driven by the core |
| data_oe_core_i | input | 1 | Core request to drive the data bus |
| strb_n_core_i | input | SW | Active-low control strobes from the core |
| h1_o | output | 1 | Clock phase H1 |
| h3_o | output | 1 | Clock phase H3, inverse of H1 |
| addr_o | output | AW | Address to the pads, held while halted |
| data_oe_o | output | 1 | Data bus output enable, low means high impedance |
| strb_n_o | output | SW | Active-low control strobes to the pads |
| halted_o | output | 1 | Clocks are stopped or waiting to restart |
| idle_o | output | 1 | Emulation-mode idle in progress |
| wake_o | output | 1 | One-cycle pulse when the core is released |
| rep_o | output | 1 | One-cycle pulse marking a repeated level request |

## Verification
The assertions watch, on every cycle, the invariants of the phases and the bus. These are the complementary H1/H3 pair, toggling while running, the frozen H1-high level once halted, the released data bus and inactive strobes, the stable held address, and the single-cycle wake pulse that coincides with the opposite-phase restart. The width filter itself can be shown only by the bench's scenarios. These compare pulses of three, four and eight cycles on different lines and check the resulting wake and repeat counts. The scenarios also cover the decode of near-miss words and the emulation idle path.

// File: rtl/clkstop_pkg.sv
// Package: shared constants and types for the clock stop/wake controller.
// Assumes H1 and H3 each toggle once per input clock cycle when running.
package clkstop_pkg;

    // Instruction word that requests a clock halt.
    localparam logic [31:0] HALT_WORD = 32'h0600_0001;

    // Input clock cycles per H1 cycle (fixed by the toggle scheme).
    localparam int CLKS_PER_H1 = 2;

    // Controller states.
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_RESUME = 2'd2,
        ST_IDLE   = 2'd3
    } clk_state_e;

endpackage

// File: rtl/clkstop_phase_gen.sv
// Module: clkstop_phase_gen
// Generates H1 and H3 as two separate flops that toggle together when
// toggle_en is high and hold otherwise. Reset puts H1 high and H3 low.
// Assumes toggle_en is the only control and the flops never disagree.
module clkstop_phase_gen (
    input  logic clk_i,
    input  logic rst_n,
    input  logic toggle_en,
    output logic h1_o,
    output logic h3_o
);

    logic h1_q;
    logic h3_q;

    // H1 phase flop: toggles when enabled.
    always_ff @(posedge clk_i) begin
        if (!rst_n)         h1_q <= 1'b1;
        else if (toggle_en) h1_q <= ~h1_q;
    end

    // H3 phase flop: toggles on the same enable, opposite reset level.
    always_ff @(posedge clk_i) begin
        if (!rst_n)         h3_q <= 1'b0;
        else if (toggle_en) h3_q <= ~h3_q;
    end

    assign h1_o = h1_q;
    assign h3_o = h3_q;

endmodule

// File: rtl/clkstop_wake_filter.sv
// Module: clkstop_wake_filter
// Synchronizes LINES active-low interrupts through two flops and counts,
// per line, consecutive low samples on the free-running clock. Raises
// qual_o on the sample that reaches MIN_CLKS and a registered rep_o pulse
// on the sample that reaches REP_CLKS. Assumes REP_CLKS > MIN_CLKS >= 1.
module clkstop_wake_filter #(
    parameter int LINES    = 4,
    parameter int MIN_CLKS = 4,
    parameter int REP_CLKS = 6
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic [LINES-1:0] int_n_i,
    output logic             qual_o,
    output logic             rep_o
);

    localparam int CW = $clog2(REP_CLKS + 1);
    localparam logic [CW-1:0] MIN_LAST = CW'(MIN_CLKS - 1);
    localparam logic [CW-1:0] REP_LAST = CW'(REP_CLKS - 1);
    localparam logic [CW-1:0] SAT_VAL  = CW'(REP_CLKS);

    logic [LINES-1:0] sync1_q;
    logic [LINES-1:0] sync2_q;
    logic [LINES-1:0] hit_min;
    logic [LINES-1:0] hit_rep;
    logic             rep_q;

    // Two-flop synchronizer for all lines; idle level is high.
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            sync1_q <= '1;
            sync2_q <= '1;
        end else begin
            sync1_q <= int_n_i;
            sync2_q <= sync1_q;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [CW-1:0] run_q;

        // Saturating count of consecutive low samples on this line.
        always_ff @(posedge clk_i) begin
            if (!rst_n)               run_q <= '0;
            else if (sync2_q[g])      run_q <= '0;
            else if (run_q != SAT_VAL) run_q <= run_q + 1'b1;
        end

        assign hit_min[g] = !sync2_q[g] && (run_q == MIN_LAST);
        assign hit_rep[g] = !sync2_q[g] && (run_q == REP_LAST);
    end

    // Register the repeat pulse so it is one clean cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_n) rep_q <= 1'b0;
        else        rep_q <= |hit_rep;
    end

    assign qual_o = |hit_min;
    assign rep_o  = rep_q;

endmodule

// File: rtl/clkstop_seq.sv
// Module: clkstop_seq
// Halt decode and stop/resume sequencer. Decides when the phase flops
// toggle: always while running or idling, once more while stopping if H1
// is low, and on the last resume cycle so the restart lands in the
// opposite phase. Assumes qual_i is a single-cycle qualification strobe.
module clkstop_seq
    import clkstop_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_n,
    input  logic        instr_valid_i,
    input  logic [31:0] instr_word_i,
    input  logic        emu_mode_i,
    input  logic        qual_i,
    input  logic        h1_i,
    output logic        toggle_en,
    output logic        halted_o,
    output logic        idle_o,
    output logic        wake_o
);

    localparam int WCW = (CLKS_PER_H1 > 1) ? $clog2(CLKS_PER_H1) : 1;
    localparam logic [WCW-1:0] W_LAST = WCW'(CLKS_PER_H1 - 1);

    clk_state_e     st_q;
    clk_state_e     st_d;
    logic [WCW-1:0] wait_q;
    logic           halt_hit;
    logic           resume_done;
    logic           wake_q;

    assign halt_hit    = instr_valid_i && (instr_word_i == HALT_WORD);
    assign resume_done = (st_q == ST_RESUME) && (wait_q == W_LAST);

    // Next-state selection for the stop/resume sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:    if (halt_hit) st_d = emu_mode_i ? ST_IDLE : ST_STOP;
            ST_STOP:   if (qual_i)   st_d = ST_RESUME;
            ST_RESUME: if (resume_done) st_d = ST_RUN;
            ST_IDLE:   if (qual_i)   st_d = ST_RUN;
            default:   st_d = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // One-H1-cycle restart delay counter.
    always_ff @(posedge clk_i) begin
        if (!rst_n)                 wait_q <= '0;
        else if (st_q != ST_RESUME) wait_q <= '0;
        else if (!resume_done)      wait_q <= wait_q + 1'b1;
    end

    // Wake pulse, aligned with the first cycle the core is released.
    always_ff @(posedge clk_i) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= resume_done || ((st_q == ST_IDLE) && qual_i);
    end

    // Phase toggle enable: run, idle, finish stopping high, restart edge.
    always_comb begin
        toggle_en = (st_q == ST_RUN) || (st_q == ST_IDLE) ||
                    ((st_q == ST_STOP) && !h1_i) || resume_done;
    end

    assign halted_o = (st_q == ST_STOP) || (st_q == ST_RESUME);
    assign idle_o   = (st_q == ST_IDLE);
    assign wake_o   = wake_q;

endmodule

// File: rtl/clkstop_bus_hold.sv
// Module: clkstop_bus_hold
// Quiets the external bus while halted: holds the last address captured
// while running, releases the data drivers and forces strobes inactive.
// Assumes halted_i comes from a register so the hold is glitch-free.
module clkstop_bus_hold #(
    parameter int AW = 24,
    parameter int SW = 4
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          halted_i,
    input  logic [AW-1:0] addr_core_i,
    input  logic          data_oe_core_i,
    input  logic [SW-1:0] strb_n_core_i,
    output logic [AW-1:0] addr_o,
    output logic          data_oe_o,
    output logic [SW-1:0] strb_n_o
);

    logic [AW-1:0] addr_q;

    // Track the core address every running cycle; freeze while halted.
    always_ff @(posedge clk_i) begin
        if (!rst_n)         addr_q <= '0;
        else if (!halted_i) addr_q <= addr_core_i;
    end

    // Pad-side selection between live and quiet values.
    always_comb begin
        addr_o    = halted_i ? addr_q : addr_core_i;
        data_oe_o = data_oe_core_i && !halted_i;
        strb_n_o  = halted_i ? '1 : strb_n_core_i;
    end

endmodule

// File: rtl/clkstop_ctrl.sv
// Module: clkstop_ctrl (top)
// Two-phase clock stop and wake controller. Ties together the halt
// sequencer, the phase flops, the interrupt width filter and the bus
// quieting. Assumes clk_i never stops and the interrupts are asynchronous.
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int AW       = 24,
    parameter int SW       = 4,
    parameter int MIN_H1   = 2,
    parameter int REP_H1   = 3
) (
    input  logic          clk_i,
    input  logic          rst_n,
    input  logic          instr_valid_i,
    input  logic [31:0]   instr_word_i,
    input  logic          emu_mode_i,
    input  logic [3:0]    int_n_i,
    input  logic [AW-1:0] addr_core_i,
    input  logic          data_oe_core_i,
    input  logic [SW-1:0] strb_n_core_i,
    output logic          h1_o,
    output logic          h3_o,
    output logic [AW-1:0] addr_o,
    output logic          data_oe_o,
    output logic [SW-1:0] strb_n_o,
    output logic          halted_o,
    output logic          idle_o,
    output logic          wake_o,
    output logic          rep_o
);

    localparam int MIN_CLKS = MIN_H1 * CLKS_PER_H1;
    localparam int REP_CLKS = REP_H1 * CLKS_PER_H1;

    logic toggle_en;
    logic qual;
    logic halted;

    clkstop_wake_filter #(
        .LINES    (4),
        .MIN_CLKS (MIN_CLKS),
        .REP_CLKS (REP_CLKS)
    ) u_filter (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .int_n_i (int_n_i),
        .qual_o  (qual),
        .rep_o   (rep_o)
    );

    clkstop_seq u_seq (
        .clk_i         (clk_i),
        .rst_n         (rst_n),
        .instr_valid_i (instr_valid_i),
        .instr_word_i  (instr_word_i),
        .emu_mode_i    (emu_mode_i),
        .qual_i        (qual),
        .h1_i          (h1_o),
        .toggle_en     (toggle_en),
        .halted_o      (halted),
        .idle_o        (idle_o),
        .wake_o        (wake_o)
    );

    clkstop_phase_gen u_phase (
        .clk_i     (clk_i),
        .rst_n     (rst_n),
        .toggle_en (toggle_en),
        .h1_o      (h1_o),
        .h3_o      (h3_o)
    );

    clkstop_bus_hold #(
        .AW (AW),
        .SW (SW)
    ) u_bus (
        .clk_i          (clk_i),
        .rst_n          (rst_n),
        .halted_i       (halted),
        .addr_core_i    (addr_core_i),
        .data_oe_core_i (data_oe_core_i),
        .strb_n_core_i  (strb_n_core_i),
        .addr_o         (addr_o),
        .data_oe_o      (data_oe_o),
        .strb_n_o       (strb_n_o)
    );

    assign halted_o = halted;

endmodule

// File: rtl/clkstop_chk.sv
// Module: clkstop_chk
// Property checker bound to clkstop_ctrl. Observes ports only.
// Assumes rst_n is held low for at least one clock edge at start.
module clkstop_chk #(
    parameter int AW = 24,
    parameter int SW = 4
) (
    input logic          clk_i,
    input logic          rst_n,
    input logic          h1_o,
    input logic          h3_o,
    input logic [AW-1:0] addr_o,
    input logic          data_oe_o,
    input logic [SW-1:0] strb_n_o,
    input logic          halted_o,
    input logic          idle_o,
    input logic          wake_o
);

    AST_PHASE_OPPOSITE: assert property (@(posedge clk_i) disable iff (!rst_n)
        h1_o != h3_o); // R2

    AST_RUN_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
        $past(rst_n) && !halted_o && !$past(halted_o) |-> h1_o != $past(h1_o)); // R2

    AST_FROZEN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
        $past(rst_n) && halted_o && $past(halted_o) |-> h1_o && !h3_o); // R3

    AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
        halted_o |-> !data_oe_o && (strb_n_o == '1)); // R5

    AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
        $past(rst_n) && halted_o && $past(halted_o) |-> $stable(addr_o)); // R5

    AST_IDLE_NOT_HALTED: assert property (@(posedge clk_i) disable iff (!rst_n)
        idle_o |-> !halted_o); // R6

    AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
        wake_o |=> !wake_o); // R8

    AST_RESUME_WAKE: assert property (@(posedge clk_i) disable iff (!rst_n)
        $past(rst_n) && $fell(halted_o) |-> wake_o && !h1_o); // R8

endmodule

bind clkstop_ctrl clkstop_chk #(.AW(AW), .SW(SW)) u_chk (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .h1_o      (h1_o),
    .h3_o      (h3_o),
    .addr_o    (addr_o),
    .data_oe_o (data_oe_o),
    .strb_n_o  (strb_n_o),
    .halted_o  (halted_o),
    .idle_o    (idle_o),
    .wake_o    (wake_o)
);

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/1ps
// Bench: directed scenarios for clkstop_ctrl, one task per scenario.
module tb_clkstop_ctrl;

    localparam int AW = 24;
    localparam int SW = 4;
    localparam logic [31:0] HALT = 32'h0600_0001;

    logic          clk_i = 1'b0;
    logic          rst_n;
    logic          instr_valid_i;
    logic [31:0]   instr_word_i;
    logic          emu_mode_i;
    logic [3:0]    int_n_i;
    logic [AW-1:0] addr_core_i;
    logic          data_oe_core_i;
    logic [SW-1:0] strb_n_core_i;
    logic          h1_o, h3_o;
    logic [AW-1:0] addr_o;
    logic          data_oe_o;
    logic [SW-1:0] strb_n_o;
    logic          halted_o, idle_o, wake_o, rep_o;

    int n_checks = 0;
    int n_fail   = 0;
    int wake_cnt = 0;
    int rep_cnt  = 0;
    logic resumed;
    logic resume_h1;
    logic resume_wake;
    logic prev_halted;

    clkstop_ctrl #(.AW(AW), .SW(SW)) dut (.*);

    always #2.5 clk_i = ~clk_i;

    // Monitor pulses and the restart cycle at the inactive edge.
    always @(negedge clk_i) begin
        if (wake_o) wake_cnt++;
        if (rep_o)  rep_cnt++;
        if (prev_halted === 1'b1 && halted_o === 1'b0) begin
            resumed     = 1'b1;
            resume_h1   = h1_o;
            resume_wake = wake_o;
        end
        prev_halted = halted_o;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic clear_mon();
        wake_cnt = 0; rep_cnt = 0; resumed = 1'b0;
    endtask

    task automatic send_word(input logic valid, input logic [31:0] word);
        @(negedge clk_i);
        instr_valid_i = valid; instr_word_i = word;
        @(negedge clk_i);
        instr_valid_i = 1'b0; instr_word_i = '0;
    endtask

    task automatic pulse(input int line, input int n);
        @(negedge clk_i);
        int_n_i[line] = 1'b0;
        nclk(n);
        int_n_i[line] = 1'b1;
    endtask

    task automatic t_reset();
        nclk(1);
        chk(h1_o === 1'b1 && h3_o === 1'b0, "R1 phases", {h1_o, h3_o}, 2'b10);
        chk(halted_o === 1'b0 && idle_o === 1'b0, "R1 flags", {halted_o, idle_o}, 0);
        chk(wake_o === 1'b0 && rep_o === 1'b0, "R1 pulses", {wake_o, rep_o}, 0);
    endtask

    task automatic t_toggle();
        logic last;
        last = h1_o;
        for (int i = 0; i < 6; i++) begin
            nclk(1);
            chk(h1_o !== last && h3_o === ~h1_o, "R2 toggle", h1_o, ~last);
            last = h1_o;
        end
    endtask

    task automatic t_near_miss();
        send_word(1'b1, 32'h0600_0000);
        send_word(1'b1, 32'h0600_0003);
        send_word(1'b0, HALT);
        nclk(3);
        chk(halted_o === 1'b0 && idle_o === 1'b0, "R4 no halt", {halted_o, idle_o}, 0);
        begin
            logic last;
            last = h1_o;
            nclk(1);
            chk(h1_o !== last, "R4 clocks run", h1_o, ~last);
        end
    endtask

    task automatic t_halt_bus();
        addr_core_i = 24'hA5_1234; data_oe_core_i = 1'b1; strb_n_core_i = '0;
        send_word(1'b1, HALT);
        nclk(2);
        chk(halted_o === 1'b1, "R3 halted", halted_o, 1);
        chk(h1_o === 1'b1 && h3_o === 1'b0, "R3 frozen phase", {h1_o, h3_o}, 2'b10);
        addr_core_i = 24'h00_BEEF;
        nclk(5);
        chk(h1_o === 1'b1 && h3_o === 1'b0, "R3 still frozen", {h1_o, h3_o}, 2'b10);
        chk(addr_o === 24'hA5_1234, "R5 addr hold", addr_o, 24'hA5_1234);
        chk(data_oe_o === 1'b0, "R5 data released", data_oe_o, 0);
        chk(strb_n_o === '1, "R5 strobes inactive", strb_n_o, 4'hF);
    endtask

    task automatic t_short_pulse();
        clear_mon();
        pulse(0, 3);
        nclk(12);
        chk(halted_o === 1'b1, "R7 short pulse ignored", halted_o, 1);
        chk(wake_cnt == 0, "R7 no wake", wake_cnt, 0);
    endtask

    task automatic t_wake(input int line);
        clear_mon();
        pulse(line, 4);
        nclk(12);
        chk(halted_o === 1'b0, $sformatf("R10 line %0d wakes", line), halted_o, 0);
        chk(wake_cnt == 1, "R8 one wake pulse", wake_cnt, 1);
        chk(rep_cnt == 0, "R9 no repeat on two-H1 pulse", rep_cnt, 0);
        chk(resumed && resume_h1 === 1'b0, "R8 opposite phase restart", resume_h1, 0);
        chk(resume_wake === 1'b1, "R8 wake with restart", resume_wake, 1);
    endtask

    task automatic t_repeat();
        send_word(1'b1, HALT);
        nclk(3);
        clear_mon();
        pulse(2, 8);
        nclk(12);
        chk(halted_o === 1'b0, "R7 long pulse wakes", halted_o, 0);
        chk(wake_cnt == 1, "R9 single wake on long pulse", wake_cnt, 1);
        chk(rep_cnt == 1, "R9 one repeat pulse", rep_cnt, 1);
    endtask

    task automatic t_emu();
        logic last;
        emu_mode_i = 1'b1;
        send_word(1'b1, HALT);
        nclk(2);
        chk(idle_o === 1'b1 && halted_o === 1'b0, "R6 idle only", {idle_o, halted_o}, 2'b10);
        last = h1_o;
        nclk(1);
        chk(h1_o !== last, "R6 clocks run in idle", h1_o, ~last);
        clear_mon();
        pulse(3, 4);
        nclk(10);
        chk(idle_o === 1'b0, "R6 idle cleared", idle_o, 0);
        chk(wake_cnt == 1, "R6 wake pulse", wake_cnt, 1);
        emu_mode_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk_i);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; instr_valid_i = 1'b0; instr_word_i = '0; emu_mode_i = 1'b0;
        int_n_i = '1; addr_core_i = '0; data_oe_core_i = 1'b0; strb_n_core_i = '1;
        prev_halted = 1'b0; resumed = 1'b0; resume_h1 = 1'b1; resume_wake = 1'b0;
        nclk(3);
        t_reset();
        rst_n = 1'b1;
        nclk(2);
        t_toggle();
        t_near_miss();
        t_halt_bus();
        t_short_pulse();
        t_wake(0);
        for (int ln = 1; ln < 4; ln++) begin
            send_word(1'b1, HALT);
            nclk(3);
            t_wake(ln);
        end
        t_repeat();
        t_emu();
        t_toggle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule